// File: doc/BRIEF.md
# External Interrupt Edge Conditioner

This block turns a set of asynchronous interrupt pins into pending flags for a small controller. Every pin passes through a two-stage synchronizer and then a per-pin glitch filter. The filter accepts a new level only after that level has held for a programmable number of clocks. Each accepted transition is then judged by the rule of its input class. Two vectored pins trigger on an edge chosen by software. One vectored pin triggers on both edges. One quasi pin triggers on rising edges only. A group of eight key pins shares one quasi flag that sets on any enabled falling edge.

Flags stay set until the host writes a 1 to their clear bit. An edge that arrives in the same cycle as the clear keeps the flag set. A single request line reports whether any vectored flag is both pending and enabled. The two quasi flags never drive the request line; software only polls them.

Each glitch filter is a state machine with five states:
- FS_INIT waits out the synchronizer after reset. It then enters FS_LOW or FS_HIGH according to the pin level, with no event (the adopt transition).
- A change of level moves FS_LOW to FS_RISE_WAIT, or FS_HIGH to FS_FALL_WAIT (the start transition).
- A return to the old level before the count completes goes back to FS_LOW or FS_HIGH with no event (the abort transition).
- Holding the new level until the count completes goes to FS_HIGH or FS_LOW and emits a one-cycle rise or fall event (the accept transition).

Top module: `xirq_detect`

## Requirements
- R1: While reset is asserted, and after its release with the pins held at constant levels, `pending` is 0 and `vec_req` is 0. The initial pin levels produce no event.
- R2: A new pin level that holds for at most FILT_LEN clocks is discarded. A new pin level that holds for FILT_LEN+1 clocks or more is accepted as an edge.
- R3: Source A sets `pending[0]`. When `edge_sel[0]` is 1 it sets on a rising edge; when `edge_sel[0]` is 0 it sets on a falling edge. The other edge direction is ignored.
- R4: Source B sets `pending[1]` by the same rule, with `edge_sel[1]` as its edge select.
- R5: The both-edge source sets `pending[2]` on a rising edge and also on a falling edge.
- R6: The quasi rising source sets `pending[3]` on a rising edge only.
- R7: `pending[4]` sets when any key pin whose `key_en` bit is 1 falls. Falling edges on disabled keys have no effect, and rising key edges have no effect.
- R8: A cycle with `clr_we` high clears every pending bit whose `clr_mask` bit is 1 and leaves the other bits unchanged. If an edge sets the same bit in that cycle, the bit stays 1.
- R9: `vec_req` is the OR over bits 0 to 2 of `pending & irq_en`. Bits 3 and 4 never drive it.
- R10: With no accepted edge and no clear, `pending` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_a_pin | input | 1 | Vectored source A, edge chosen by software |
| irq_b_pin | input | 1 | Vectored source B, edge chosen by software |
| irq_both_pin | input | 1 | Vectored source, triggers on both edges |
| quasi_rise_pin | input | 1 | Quasi source, triggers on rising edges |
| key_pins | input | KEY_NUM | Key-scan pins, trigger on falling edges |
| edge_sel | input | 2 | Bit 0 is for A, bit 1 is for B; 1 selects rising, 0 selects falling |
| key_en | input | KEY_NUM | Per-key enable for the key flag |
| irq_en | input | 3 | Request enables for pending bits 0 to 2 |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 5 | Bits to clear when `clr_we` is high |
| pending | output | 5 | Pending flags (A, B, both-edge, quasi rise, keys) |
| vec_req | output | 1 | Combined vectored request |

## Verification
The assertions take for granted that `clr_mask`, `irq_en` and `clr_we` are driven to known levels in every clocked cycle after reset. They also assume the pins are clean digital levels, so a filter input can change only between clock samples. The stimulus changes pins and controls only just after a rising edge. It holds every level for a whole number of clocks, so each filter sees whole-cycle runs. Key enables and edge selects are changed only while the pins they govern are stable, so an edge is never judged under a half-updated rule.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int SRC_NUM   = 5;
    localparam int VEC_NUM   = 3;
    localparam int IDX_A     = 0;
    localparam int IDX_B     = 1;
    localparam int IDX_BOTH  = 2;
    localparam int IDX_QRISE = 3;
    localparam int IDX_KEYS  = 4;

    typedef enum logic [2:0] {
        FS_INIT,
        FS_LOW,
        FS_RISE_WAIT,
        FS_HIGH,
        FS_FALL_WAIT
    } filt_state_e;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/xirq_filter.sv
module xirq_filter
    import xirq_pkg::*;
#(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int MAX_CNT = (FILT_LEN > SYNC_STAGES) ? FILT_LEN : SYNC_STAGES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] FILT_LAST = CNT_W'(FILT_LEN);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(SYNC_STAGES);

    filt_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_INIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FS_INIT: begin
                if (cnt_q == INIT_LAST) begin
                    state_d = lvl_i ? FS_HIGH : FS_LOW;   // adopt
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            FS_LOW: begin
                if (lvl_i) begin
                    state_d = FS_RISE_WAIT;               // start
                    cnt_d   = CNT_W'(1);
                end
            end
            FS_RISE_WAIT: begin
                if (!lvl_i) begin
                    state_d = FS_LOW;                     // abort
                    cnt_d   = '0;
                end else if (cnt_q == FILT_LAST) begin
                    state_d = FS_HIGH;                    // accept
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            FS_HIGH: begin
                if (!lvl_i) begin
                    state_d = FS_FALL_WAIT;               // start
                    cnt_d   = CNT_W'(1);
                end
            end
            FS_FALL_WAIT: begin
                if (lvl_i) begin
                    state_d = FS_HIGH;                    // abort
                    cnt_d   = '0;
                end else if (cnt_q == FILT_LAST) begin
                    state_d = FS_LOW;                     // accept
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = FS_INIT;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            FS_RISE_WAIT: rise_o = lvl_i && (cnt_q == FILT_LAST);
            FS_FALL_WAIT: fall_o = !lvl_i && (cnt_q == FILT_LAST);
            default: ;
        endcase
    end

    // independent run-length tracker for the stability check
    logic             prev_q;
    logic [CNT_W-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= lvl_i;
            if (lvl_i != prev_q)     run_q <= '0;
            else if (run_q != FILT_LAST) run_q <= run_q + 1'b1;
        end
    end

    a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));

    a_r2_rise_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (lvl_i && prev_q && (run_q >= FILT_LAST - 1'b1)));

    a_r2_fall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!lvl_i && !prev_q && (run_q >= FILT_LAST - 1'b1)));

endmodule

// File: rtl/xirq_flags.sv
module xirq_flags
    import xirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_NUM-1:0] set_i,
    input  logic               clr_we_i,
    input  logic [SRC_NUM-1:0] clr_mask_i,
    input  logic [VEC_NUM-1:0] irq_en_i,
    output logic [SRC_NUM-1:0] pending_o,
    output logic               vec_req_o
);
    logic [SRC_NUM-1:0] pend_q, clr_bits;

    assign clr_bits = clr_we_i ? clr_mask_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_bits) | set_i;
    end

    assign pending_o = pend_q;
    assign vec_req_o = |(pend_q[VEC_NUM-1:0] & irq_en_i);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pending_o & $past(set_i)) == $past(set_i)));

    a_r8_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((pending_o & $past(clr_mask_i & ~set_i)) == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i && set_i == '0) |=> $stable(pending_o));

    a_r9_quasi_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_o[VEC_NUM-1:0] & irq_en_i) == '0) |-> !vec_req_o);

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
#(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int KEY_NUM     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_a_pin,
    input  logic               irq_b_pin,
    input  logic               irq_both_pin,
    input  logic               quasi_rise_pin,
    input  logic [KEY_NUM-1:0] key_pins,
    input  logic [1:0]         edge_sel,
    input  logic [KEY_NUM-1:0] key_en,
    input  logic [VEC_NUM-1:0] irq_en,
    input  logic               clr_we,
    input  logic [SRC_NUM-1:0] clr_mask,
    output logic [SRC_NUM-1:0] pending,
    output logic               vec_req
);
    localparam int PIN_NUM  = 4 + KEY_NUM;
    localparam int KEY_BASE = 4;

    logic [PIN_NUM-1:0] raw_pins, sync_pins, rise_ev, fall_ev;
    logic [SRC_NUM-1:0] set_ev;

    assign raw_pins = {key_pins, quasi_rise_pin, irq_both_pin, irq_b_pin, irq_a_pin};

    xirq_sync #(.WIDTH(PIN_NUM), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_pins),
        .q_o   (sync_pins)
    );

    generate
        for (genvar p = 0; p < PIN_NUM; p++) begin : g_filt
            xirq_filter #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (sync_pins[p]),
                .rise_o (rise_ev[p]),
                .fall_o (fall_ev[p])
            );
        end
    endgenerate

    // per-class edge rules
    always_comb begin
        set_ev            = '0;
        set_ev[IDX_A]     = edge_sel[0] ? rise_ev[0] : fall_ev[0];
        set_ev[IDX_B]     = edge_sel[1] ? rise_ev[1] : fall_ev[1];
        set_ev[IDX_BOTH]  = rise_ev[2] | fall_ev[2];
        set_ev[IDX_QRISE] = rise_ev[3];
        set_ev[IDX_KEYS]  = |(fall_ev[PIN_NUM-1:KEY_BASE] & key_en);
    end

    xirq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_ev),
        .clr_we_i   (clr_we),
        .clr_mask_i (clr_mask),
        .irq_en_i   (irq_en),
        .pending_o  (pending),
        .vec_req_o  (vec_req)
    );

    a_r6_quasi_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev[3] |-> !set_ev[IDX_QRISE]);

    a_r7_masked_keys: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall_ev[PIN_NUM-1:KEY_BASE] & key_en) == '0) |-> !set_ev[IDX_KEYS]);

endmodule

// File: tb/xirq_detect_tb_top.sv
`timescale 1ns/1ps
module xirq_detect_tb_top;
    localparam int FILT_LEN = 4;
    localparam int SETTLE   = 3 * FILT_LEN + 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_pin = 1'b0, b_pin = 1'b0, both_pin = 1'b0, qr_pin = 1'b0;
    logic [7:0] keys = 8'hFF, ken = 8'hFF;
    logic [1:0] esel = 2'b00;
    logic [2:0] ien = 3'b111;
    logic       clr_we = 1'b0;
    logic [4:0] clr_mask = 5'b0;
    logic [4:0] pending;
    logic       vec_req;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xirq_detect #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(2), .KEY_NUM(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_a_pin(a_pin), .irq_b_pin(b_pin),
        .irq_both_pin(both_pin), .quasi_rise_pin(qr_pin), .key_pins(keys),
        .edge_sel(esel), .key_en(ken), .irq_en(ien), .clr_we(clr_we),
        .clr_mask(clr_mask), .pending(pending), .vec_req(vec_req)
    );

    // {a, b, both, qrise, keys[7:0], edge_sel[1:0], key_en[7:0], expected pending[4:0]}
    localparam logic [26:0] STEPS [13] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b01, 8'hFF, 5'b00001}, // R3 rise, rising sel
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b01, 8'hFF, 5'b00000}, // R3 fall ignored
        {1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 2'b00, 8'hFF, 5'b00000}, // R4 rise ignored
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b00, 8'hFF, 5'b00010}, // R4 fall, falling sel
        {1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 2'b00, 8'hFF, 5'b00100}, // R5 rise
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b00, 8'hFF, 5'b00100}, // R5 fall
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 2'b00, 8'hFF, 5'b01000}, // R6 rise
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b00, 8'hFF, 5'b00000}, // R6 fall ignored
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hFE, 2'b00, 8'hFE, 5'b00000}, // R7 disabled key
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b00, 8'hFF, 5'b00000}, // R7 rise ignored
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h7F, 2'b00, 8'hFF, 5'b10000}, // R7 enabled fall
        {1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b00, 8'hFF, 5'b00000}, // R3 rise ignored
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b00, 8'hFF, 5'b00001}  // R3 fall, falling sel
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_mask = 5'h1F;
        clr_we   = 1'b1;
        tick(1);
        clr_we   = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(3);
        chk("R1 pending in reset", 32'(pending), 32'h0);
        chk("R1 vec_req in reset", 32'(vec_req), 32'h0);
        rst_n = 1'b1;
        tick(SETTLE);
        chk("R1 pending after reset", 32'(pending), 32'h0);
        chk("R1 vec_req after reset", 32'(vec_req), 32'h0);

        for (int i = 0; i < 13; i++) begin
            logic [26:0] e;
            e    = STEPS[i];
            esel = e[14:13];
            ken  = e[12:5];
            tick(1);
            clear_all();
            a_pin = e[26]; b_pin = e[25]; both_pin = e[24]; qr_pin = e[23];
            keys  = e[22:15];
            tick(SETTLE);
            chk($sformatf("R3-7 table step %0d pending", i), 32'(pending), 32'(e[4:0]));
            chk($sformatf("R9 table step %0d vec_req", i), 32'(vec_req), 32'(|e[2:0]));
        end

        // R9: request gated by enables, quasi flags excluded (pending = 00001 here)
        ien = 3'b110; #1;
        chk("R9 disabled source A", 32'(vec_req), 32'h0);
        qr_pin = 1'b1;
        tick(SETTLE);
        chk("R6 quasi flag set", 32'(pending), 32'h09);
        chk("R9 quasi does not request", 32'(vec_req), 32'h0);
        ien = 3'b001; #1;
        chk("R9 enabled source A", 32'(vec_req), 32'h1);

        // R8: partial clear, R10 hold
        clr_mask = 5'b00001; clr_we = 1'b1;
        tick(1);
        clr_we = 1'b0;
        chk("R8 partial clear", 32'(pending), 32'h08);
        ien = 3'b111; #1;
        chk("R9 quasi only, no request", 32'(vec_req), 32'h0);
        tick(30);
        chk("R10 flags held", 32'(pending), 32'h08);

        // R2: short pulse rejected, long pulse accepted
        clear_all();
        both_pin = 1'b1;
        tick(FILT_LEN);
        both_pin = 1'b0;
        tick(SETTLE);
        chk("R2 pulse of FILT_LEN clocks dropped", 32'(pending), 32'h0);
        both_pin = 1'b1;
        tick(FILT_LEN + 1);
        both_pin = 1'b0;
        tick(SETTLE);
        chk("R2 pulse of FILT_LEN+1 clocks taken", 32'(pending), 32'h04);

        // R8: edge in the same cycle as a clear keeps the flag
        clear_all();
        chk("R8 clear before race", 32'(pending), 32'h0);
        both_pin = 1'b1;
        tick(FILT_LEN + 2);
        clr_mask = 5'h1F; clr_we = 1'b1;
        tick(1);
        clr_we = 1'b0;
        chk("R8 set wins over clear", 32'(pending), 32'h04);
        tick(SETTLE);
        chk("R10 flag held after race", 32'(pending), 32'h04);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule